// File: doc/BRIEF.md
# Fetch address queue manager

This block holds the program counters of an instruction fetch front end in three slots: the current fetch address, the next one, and the one after it. Each slot carries a valid bit, an address and a flag saying whether the address is a taken delay-slot target. The current slot and the next slot also hold a per-lane instruction enable mask.

The block has three ports. On the prediction port, the block shows a branch predictor the previous and current program counters. The predictor answers with the following program counter and a lane mask. On the fetch port, the block issues the current slot's address and mask to the instruction cache. On the redirect port, an exception or a mispredict restarts the queue at a new address.

Prediction runs one slot ahead of fetch. When the current slot is empty and both later slots are full, the queue moves forward by one slot in the same clock edge. This lets a predict handshake and a fetch handshake both complete every cycle.

Top module: `fetch_pc_queue`

## Requirements
- R1: After the synchronous active-low reset, `redir_ready` is 1, and both `pred_valid` and `fetch_valid` are 0.
- R2: When `redir_valid` is high at a rising edge, then after that edge `fetch_valid` is 0, `pred_valid` is 1, `pred_cur_pc` equals the redirect address and `pred_cur_dst` is 0.
- R3: `pred_valid` is 1 exactly when the next slot is valid and the slot after it is empty. `pred_cur_pc` and `pred_cur_dst` show the next slot. `pred_prev_pc` shows the current slot's address whenever that slot is valid.
- R4: On a completed predict handshake, the predicted PC and its delay-slot flag fill the slot after next. The returned lane mask is stored with the next slot and later appears on `fetch_lane_en` together with that slot's address.
- R5: `fetch_valid` is 1 exactly when the current slot is valid. `fetch_addr`, `fetch_lane_en` and `fetch_dst` show that slot. A completed fetch handshake empties the slot. While `fetch_ready` is low, the fetch outputs hold.
- R6: When the current slot would be empty after an edge and both later slots are valid, the slots shift by one at that edge: the next slot becomes current and the slot after next becomes next.
- R7: A redirect accepted in the same cycle as a predict and/or a fetch handshake takes priority. The queue ends as described in R2, and the predicted PC is discarded.
- R8: `fetch_iptr`, `fetch_bstate` and `fetch_upd_id` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redir_valid | input | 1 | Redirect request |
| redir_addr | input | ADDR_W | Redirect target address |
| redir_ready | output | 1 | Redirect acknowledge (always ready) |
| pred_valid | output | 1 | Prediction request |
| pred_ready | input | 1 | Prediction acknowledge |
| pred_prev_pc | output | ADDR_W | Current slot address |
| pred_cur_pc | output | ADDR_W | Next slot address |
| pred_cur_dst | output | 1 | Next slot delay-slot-taken flag |
| pred_next_pc | input | ADDR_W | Predicted following PC |
| pred_next_dst | input | 1 | Predicted PC is a taken delay-slot target |
| pred_lane_en | input | LANES | Lane mask for the next slot |
| fetch_valid | output | 1 | Fetch request |
| fetch_ready | input | 1 | Fetch acknowledge |
| fetch_addr | output | ADDR_W | Current slot address |
| fetch_lane_en | output | LANES | Current slot lane mask |
| fetch_dst | output | 1 | Current slot delay-slot-taken flag |
| fetch_iptr | output | PTR_W | Instruction pointer field, zero |
| fetch_bstate | output | BST_W | Branch state field, zero |
| fetch_upd_id | output | UPD_W | Branch-update id field, zero |

## Verification
The hardest situation to reach is an edge where a predict handshake fills the third slot while a fetch handshake empties the first slot. The shift then depends on state written in that same edge, and a redirect may arrive at the same time and override everything. The bench cycles through the eight combinations of redirect, predict-acknowledge and fetch-acknowledge over several thousand cycles, with redirects kept rare so that long streaming runs form between them. A cycle-level model of the three slots, written from the requirements, predicts every output.

// File: rtl/fetch_pc_queue.sv
module fetch_pc_queue #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  parameter int PTR_W  = 2,
  parameter int BST_W  = 3,
  parameter int UPD_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_addr,
  output logic              redir_ready,
  output logic              pred_valid,
  input  logic              pred_ready,
  output logic [ADDR_W-1:0] pred_prev_pc,
  output logic [ADDR_W-1:0] pred_cur_pc,
  output logic              pred_cur_dst,
  input  logic [ADDR_W-1:0] pred_next_pc,
  input  logic              pred_next_dst,
  input  logic [LANES-1:0]  pred_lane_en,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [LANES-1:0]  fetch_lane_en,
  output logic              fetch_dst,
  output logic [PTR_W-1:0]  fetch_iptr,
  output logic [BST_W-1:0]  fetch_bstate,
  output logic [UPD_W-1:0]  fetch_upd_id
);

  localparam logic [LANES-1:0] FIRST_LANE = LANES'(1);

  logic              c_v, n_v, nn_v;
  logic [ADDR_W-1:0] c_a, n_a, nn_a;
  logic              c_d, n_d, nn_d;
  logic [LANES-1:0]  c_e, n_e;

  logic              c_v_d, n_v_d, nn_v_d;
  logic [ADDR_W-1:0] c_a_d, n_a_d, nn_a_d;
  logic              c_d_d, n_d_d, nn_d_d;
  logic [LANES-1:0]  c_e_d, n_e_d;

  logic redir_fire, pred_fire, fetch_fire;

  assign redir_ready  = 1'b1;
  assign redir_fire   = redir_valid & redir_ready;

  assign pred_valid   = n_v & ~nn_v;
  assign pred_fire    = pred_valid & pred_ready;
  assign pred_prev_pc = c_a;
  assign pred_cur_pc  = n_a;
  assign pred_cur_dst = n_d;

  assign fetch_valid   = c_v;
  assign fetch_fire    = fetch_valid & fetch_ready;
  assign fetch_addr    = c_a;
  assign fetch_lane_en = c_e;
  assign fetch_dst     = c_d;
  assign fetch_iptr    = '0;
  assign fetch_bstate  = '0;
  assign fetch_upd_id  = '0;

  always_comb begin
    c_v_d = c_v;   c_a_d = c_a;   c_d_d = c_d;   c_e_d = c_e;
    n_v_d = n_v;   n_a_d = n_a;   n_d_d = n_d;   n_e_d = n_e;
    nn_v_d = nn_v; nn_a_d = nn_a; nn_d_d = nn_d;

    if (pred_fire) begin
      nn_v_d = 1'b1;
      nn_a_d = pred_next_pc;
      nn_d_d = pred_next_dst;
      n_e_d  = pred_lane_en;
    end

    if (fetch_fire)
      c_v_d = 1'b0;

    if (!c_v_d && n_v_d && nn_v_d) begin
      c_v_d  = 1'b1;
      c_a_d  = n_a_d;
      c_d_d  = n_d_d;
      c_e_d  = n_e_d;
      n_a_d  = nn_a_d;
      n_d_d  = nn_d_d;
      nn_v_d = 1'b0;
    end

    if (redir_fire) begin
      c_v_d  = 1'b0;
      n_v_d  = 1'b1;
      n_a_d  = redir_addr;
      n_d_d  = 1'b0;
      n_e_d  = FIRST_LANE;
      nn_v_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_v  <= 1'b0;
      n_v  <= 1'b0;
      nn_v <= 1'b0;
    end else begin
      c_v  <= c_v_d;
      n_v  <= n_v_d;
      nn_v <= nn_v_d;
    end
  end

  always_ff @(posedge clk) begin
    c_a  <= c_a_d;  c_d  <= c_d_d;  c_e <= c_e_d;
    n_a  <= n_a_d;  n_d  <= n_d_d;  n_e <= n_e_d;
    nn_a <= nn_a_d; nn_d <= nn_d_d;
  end

  // R2
  redirect_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (pred_valid && !fetch_valid && !pred_cur_dst
                     && pred_cur_pc == $past(redir_addr)));

  // R5
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !redir_valid) |=>
      (fetch_valid && $stable(fetch_addr) && $stable(fetch_lane_en)));

  // R4
  mask_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && pred_ready && !fetch_valid && !redir_valid) |=>
      (fetch_valid && fetch_addr == $past(pred_cur_pc)
       && fetch_lane_en == $past(pred_lane_en)));

  // R6
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && pred_ready && !fetch_valid && !redir_valid) |=>
      (pred_valid && pred_cur_pc == $past(pred_next_pc)
       && pred_cur_dst == $past(pred_next_dst)));

  // R3
  pred_feeds_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && pred_ready && !redir_valid) |=> fetch_valid);

  // R7
  redirect_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && (pred_ready || fetch_ready)) |=> !fetch_valid);

endmodule

// File: tb/fetch_pc_queue_test.sv
module fetch_pc_queue_test;
  localparam int AW = 32;
  localparam int LN = 4;

  logic clk = 0, rst_n = 0;
  logic redir_valid = 0, pred_ready = 0, fetch_ready = 0;
  logic [AW-1:0] redir_addr = '0, pred_next_pc = '0;
  logic pred_next_dst = 0;
  logic [LN-1:0] pred_lane_en = '0;
  logic redir_ready, pred_valid, pred_cur_dst, fetch_valid, fetch_dst;
  logic [AW-1:0] pred_prev_pc, pred_cur_pc, fetch_addr;
  logic [LN-1:0] fetch_lane_en;
  logic [1:0] fetch_iptr;
  logic [2:0] fetch_bstate, fetch_upd_id;

  int checks = 0, fails = 0;

  fetch_pc_queue #(.ADDR_W(AW), .LANES(LN)) uut (
    .clk(clk), .rst_n(rst_n),
    .redir_valid(redir_valid), .redir_addr(redir_addr), .redir_ready(redir_ready),
    .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_prev_pc(pred_prev_pc),
    .pred_cur_pc(pred_cur_pc), .pred_cur_dst(pred_cur_dst), .pred_next_pc(pred_next_pc),
    .pred_next_dst(pred_next_dst), .pred_lane_en(pred_lane_en),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .fetch_lane_en(fetch_lane_en), .fetch_dst(fetch_dst), .fetch_iptr(fetch_iptr),
    .fetch_bstate(fetch_bstate), .fetch_upd_id(fetch_upd_id));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench model of the three slots
  logic mc_v, mn_v, mnn_v, mc_d, mn_d, mnn_d;
  logic [AW-1:0] mc_a, mn_a, mnn_a;
  logic [LN-1:0] mc_e, mn_e;

  task automatic model_step();
    logic pf, ff;
    pf = mn_v && !mnn_v && pred_ready;
    ff = mc_v && fetch_ready;
    if (pf) begin mnn_v = 1; mnn_a = pred_next_pc; mnn_d = pred_next_dst; mn_e = pred_lane_en; end
    if (ff) mc_v = 0;
    if (!mc_v && mn_v && mnn_v) begin
      mc_v = 1; mc_a = mn_a; mc_d = mn_d; mc_e = mn_e;
      mn_a = mnn_a; mn_d = mnn_d; mnn_v = 0;
    end
    if (redir_valid) begin
      mc_v = 0; mn_v = 1; mn_a = redir_addr; mn_d = 0; mn_e = 4'b0001; mnn_v = 0;
    end
  endtask

  task automatic compare();
    chk("R3 pred_valid", AW'(pred_valid), AW'(mn_v && !mnn_v));
    chk("R5 fetch_valid", AW'(fetch_valid), AW'(mc_v));
    if (mn_v && !mnn_v) begin
      chk("R3 pred_cur_pc", pred_cur_pc, mn_a);
      chk("R3 pred_cur_dst", AW'(pred_cur_dst), AW'(mn_d));
      if (mc_v) chk("R3 pred_prev_pc", pred_prev_pc, mc_a);
    end
    if (mc_v) begin
      chk("R5 fetch_addr", fetch_addr, mc_a);
      chk("R4 fetch_lane_en", AW'(fetch_lane_en), AW'(mc_e));
      chk("R5 fetch_dst", AW'(fetch_dst), AW'(mc_d));
    end
    chk("R8 aux fields", AW'({fetch_iptr, fetch_bstate, fetch_upd_id}), '0);
    chk("R1 redir_ready", AW'(redir_ready), 1);
  endtask

  task automatic cyc();
    #1 compare();
    model_step();
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    mc_v = 0; mn_v = 0; mnn_v = 0; mc_d = 0; mn_d = 0; mnn_d = 0;
    mc_a = '0; mn_a = '0; mnn_a = '0; mc_e = '0; mn_e = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 reset pred_valid", AW'(pred_valid), 0);
    chk("R1 reset fetch_valid", AW'(fetch_valid), 0);
    chk("R1 reset redir_ready", AW'(redir_ready), 1);

    // R2 redirect to 0x100
    redir_valid = 1; redir_addr = 32'h100;
    cyc();
    redir_valid = 0;
    chk("R2 pred_valid", AW'(pred_valid), 1);
    chk("R2 pred_cur_pc", pred_cur_pc, 32'h100);
    chk("R2 pred_cur_dst", AW'(pred_cur_dst), 0);
    chk("R2 fetch_valid", AW'(fetch_valid), 0);

    // R4 R6 predict 0x200 with mask 0110, delay-slot flag set
    pred_ready = 1; pred_next_pc = 32'h200; pred_lane_en = 4'b0110; pred_next_dst = 1;
    cyc();
    pred_ready = 0;
    chk("R6 fetch_addr after shift", fetch_addr, 32'h100);
    chk("R4 mask with fetched slot", AW'(fetch_lane_en), 4'b0110);
    chk("R6 pred_cur_pc after shift", pred_cur_pc, 32'h200);
    chk("R6 pred_cur_dst after shift", AW'(pred_cur_dst), 1);
    chk("R3 pred_prev_pc", pred_prev_pc, 32'h100);

    // R5 hold while fetch_ready low
    cyc();
    chk("R5 hold fetch_valid", AW'(fetch_valid), 1);
    chk("R5 hold fetch_addr", fetch_addr, 32'h100);

    // R7 redirect with predict and fetch in same cycle
    redir_valid = 1; redir_addr = 32'h840; pred_ready = 1; fetch_ready = 1;
    pred_next_pc = 32'h300;
    cyc();
    redir_valid = 0; pred_ready = 0; fetch_ready = 0;
    chk("R7 fetch_valid cleared", AW'(fetch_valid), 0);
    chk("R7 pred_cur_pc", pred_cur_pc, 32'h840);
    chk("R7 pred_valid", AW'(pred_valid), 1);

    // sweep over all handshake combinations against the model
    for (int k = 0; k < 6000; k++) begin
      logic [2:0] combo;
      combo = 3'(k ^ (k >> 3));
      redir_valid   = combo[2] && (k % 7 == 3);
      redir_addr    = 32'h1000 + 32'(k) * 8;
      pred_ready    = combo[1] | (k % 5 == 0);
      fetch_ready   = combo[0] | (k % 3 == 0);
      pred_next_pc  = 32'h4000 + 32'(k) * 4;
      pred_next_dst = k[1];
      pred_lane_en  = 4'(k * 3 + 1);
      cyc();
    end
    redir_valid = 0; pred_ready = 0; fetch_ready = 0;
    cyc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule